// File: doc/BRIEF.md
# Ping-Pong Transpose Buffer for a Separable 2-D Haar Transform

This block sits between the row pass and the column pass of a separable two-dimensional Haar transform working on an N×N tile. The row pass streams its coefficients in, one word per handshake, in row-major order. The block computes a transposed address for each word and stores it, so that each incoming row vector lands in memory as a column. A fetch sequencer then reads the stored tile back in plain sequential order. The second 1-D pass therefore receives each original column as one contiguous vector.

The storage holds two tiles. While one tile drains to the column pass, the next one can be filled. Each tile slot carries a pending flag. The flag is set when the last of the N² words has been written, and it is cleared when the last word has been read out. The fetch side never reads a slot whose flag is clear. The write side is refused while both slots are pending.

Both data sides use valid/ready handshakes. A word moves on a clock edge where valid and ready are both high. The write side must hold its word and valid until the word is taken. The read side holds its word and valid steady for as long as ready stays low.

Top module: `tpose_buffer`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `out_valid` is 0, `in_ready` is 1 and `both_pending` is 0.
- R2: The tile enters in row-major order, so the word at stream index r·N+c is element (r,c). The output stream of that tile carries element (r,c) at stream index c·N+r. The output is the transpose, read out in row-major order.
- R3: A word is stored only on an edge where `in_valid` and `in_ready` are both high. Cycles with `in_valid` low add no word to the tile and shift no later word.
- R4: `out_valid` for a tile goes high in the cycle right after the edge that accepts that tile's N²-th word, and not before.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value. No word is dropped or repeated.
- R6: A second tile can be written while the first is being read out. Tiles leave in the order they were written.
- R7: When two tiles are pending readout, `both_pending` is 1 and `in_ready` is 0. A word offered then is not taken. `in_ready` returns to 1 in the cycle after the edge that accepts the final word of the older tile.
- R8: Once a tile's last word has been read and no other tile is pending, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Row-pass coefficient present |
| in_data | input | W | Row-pass coefficient |
| in_ready | output | 1 | Buffer can take a coefficient |
| out_valid | output | 1 | Transposed coefficient available (fetch request) |
| out_data | output | W | Transposed coefficient |
| out_ready | input | 1 | Column pass is free to take a word |
| both_pending | output | 1 | Both tile slots are waiting for readout |

## Verification
The assertions assume that the producer keeps a word stable while it waits, and that every tile is exactly N² accepted words with no framing signal. The bench meets this by driving a whole tile per call and holding `in_valid` and `in_data` until a handshake completes. The bench changes inputs only at the falling edge, which keeps the handshake rules valid. The tile counting in the checker assumes that reset clears any partial tile. Each scenario therefore starts either from reset or from an empty buffer.

// File: rtl/tpose_pkg.sv
package tpose_pkg;
  localparam int SLOTS = 2;
  typedef logic slot_t;
  function automatic slot_t flip(slot_t s);
    return ~s;
  endfunction
endpackage

// File: rtl/tpose_wr_ctrl.sv
module tpose_wr_ctrl #(
  parameter int N = 8,
  localparam int LN = $clog2(N),
  localparam int AW = 2 * LN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  output logic [AW-1:0]     wr_addr,
  output tpose_pkg::slot_t  wr_slot,
  output logic              wr_last
);
  logic [LN-1:0] col_q, row_q;

  // transposed placement: column index selects the stored row
  assign wr_addr = {col_q, row_q};
  assign wr_last = (col_q == LN'(N - 1)) && (row_q == LN'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      row_q   <= '0;
      wr_slot <= 1'b0;
    end else if (accept) begin
      if (col_q == LN'(N - 1)) begin
        col_q <= '0;
        if (row_q == LN'(N - 1)) begin
          row_q   <= '0;
          wr_slot <= tpose_pkg::flip(wr_slot);
        end else begin
          row_q <= row_q + 1'b1;
        end
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tpose_fetch.sv
module tpose_fetch #(
  parameter int N = 8,
  localparam int LN = $clog2(N),
  localparam int AW = 2 * LN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  output logic [AW-1:0]     rd_addr,
  output tpose_pkg::slot_t  rd_slot,
  output logic              rd_last
);
  assign rd_last = (rd_addr == AW'(N * N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr <= '0;
      rd_slot <= 1'b0;
    end else if (take) begin
      rd_addr <= rd_addr + 1'b1;
      if (rd_last) rd_slot <= tpose_pkg::flip(rd_slot);
    end
  end
endmodule

// File: rtl/tpose_store.sv
module tpose_store #(
  parameter int N = 8,
  parameter int W = 16,
  localparam int LN = $clog2(N),
  localparam int AW = 2 * LN,
  localparam int DEPTH = N * N
) (
  input  logic              clk,
  input  logic              we,
  input  tpose_pkg::slot_t  wslot,
  input  logic [AW-1:0]     waddr,
  input  logic [W-1:0]      wdata,
  input  tpose_pkg::slot_t  rslot,
  input  logic [AW-1:0]     raddr,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] rd_each [tpose_pkg::SLOTS];

  for (genvar s = 0; s < tpose_pkg::SLOTS; s++) begin : g_slot
    logic [W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (int'(wslot) == s)) cells[waddr] <= wdata;
    end
    assign rd_each[s] = cells[raddr];
  end

  assign rdata = rd_each[rslot];
endmodule

// File: rtl/tpose_buffer.sv
module tpose_buffer #(
  parameter int N = 8,
  parameter int W = 16,
  localparam int LN = $clog2(N),
  localparam int AW = 2 * LN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready,
  output logic         both_pending
);
  logic [tpose_pkg::SLOTS-1:0] pend_q;
  logic [AW-1:0]    wr_addr, rd_addr;
  tpose_pkg::slot_t wr_slot, rd_slot;
  logic             wr_last, rd_last;
  logic             acc_w, acc_r;

  assign in_ready     = ~pend_q[wr_slot];
  assign out_valid    = pend_q[rd_slot];
  assign both_pending = &pend_q;
  assign acc_w        = in_valid & in_ready;
  assign acc_r        = out_valid & out_ready;

  tpose_wr_ctrl #(.N(N)) wr_i (
    .clk(clk), .rst_n(rst_n), .accept(acc_w),
    .wr_addr(wr_addr), .wr_slot(wr_slot), .wr_last(wr_last)
  );

  tpose_fetch #(.N(N)) rd_i (
    .clk(clk), .rst_n(rst_n), .take(acc_r),
    .rd_addr(rd_addr), .rd_slot(rd_slot), .rd_last(rd_last)
  );

  tpose_store #(.N(N), .W(W)) mem_i (
    .clk(clk), .we(acc_w), .wslot(wr_slot), .waddr(wr_addr), .wdata(in_data),
    .rslot(rd_slot), .raddr(rd_addr), .rdata(out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      for (int s = 0; s < tpose_pkg::SLOTS; s++) begin
        if (acc_w && wr_last && (int'(wr_slot) == s)) pend_q[s] <= 1'b1;
        else if (acc_r && rd_last && (int'(rd_slot) == s)) pend_q[s] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tpose_buffer_chk.sv
module tpose_buffer_chk #(
  parameter int N = 8,
  parameter int W = 16,
  localparam int NN = N * N,
  localparam int CW = $clog2(NN)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_data,
  input logic         in_ready,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         out_ready,
  input logic         both_pending
);
  logic [CW-1:0] wcnt, rcnt;
  logic [1:0]    tiles;
  logic          w_end, r_end;

  assign w_end = in_valid && in_ready && (wcnt == CW'(NN - 1));
  assign r_end = out_valid && out_ready && (rcnt == CW'(NN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0; rcnt <= '0; tiles <= '0;
    end else begin
      if (in_valid && in_ready) wcnt <= w_end ? '0 : wcnt + 1'b1;
      if (out_valid && out_ready) rcnt <= r_end ? '0 : rcnt + 1'b1;
      tiles <= tiles + {1'b0, w_end} - {1'b0, r_end};
    end
  end

  always @(posedge clk) begin
    if (!rst_n) p_reset_idle_r1: assert (!out_valid && in_ready && !both_pending);
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_valid_tiles_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (tiles != 2'd0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tiles <= 2'd2);

  p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready == (tiles != 2'd2)) && (both_pending == (tiles == 2'd2)));

  p_drain_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    r_end && tiles == 2'd1 && !w_end |=> !out_valid);
endmodule

bind tpose_buffer tpose_buffer_chk #(.N(N), .W(W)) chk_i (.*);

// File: tb/tpose_buffer_tb_top.sv
module tpose_buffer_tb_top;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int NN = N * N;

  typedef struct packed {
    logic [15:0] base;
    logic [7:0]  in_gap;
    logic [7:0]  out_stall;
  } scen_t;

  localparam int NSC = 4;
  localparam scen_t SCEN [NSC] = '{
    '{16'h0000, 8'h00, 8'h00},
    '{16'h1100, 8'h55, 8'h00},
    '{16'h2200, 8'h00, 8'hFF},
    '{16'h3300, 8'h93, 8'hFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, both_pending;
  logic [W-1:0] out_data;

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  tpose_buffer #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .both_pending(both_pending)
  );

  function automatic logic [W-1:0] elem(logic [15:0] base, int r, int c);
    return W'(base + 16'(r * 16 + c));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
    end
  end

  // writes one tile; expect_idle checks that no tile is readable yet (R4)
  task automatic write_tile(logic [15:0] base, logic [7:0] gap, bit expect_idle);
    int k = 0, t = 0;
    while (k < NN) begin
      @(negedge clk);
      if (expect_idle) chk("R4 early", 32'(out_valid), 32'd0);
      if (gap[t % 8]) begin
        in_valid = 1'b0;   // R3: idle cycle must not add a word
      end else begin
        in_valid = 1'b1;
        in_data  = elem(base, k / N, k % N);
        @(posedge clk);
        if (in_ready) k++;
        @(negedge clk);
        in_valid = 1'b0;
        if (expect_idle && k == NN) chk("R4 ready after last write", 32'(out_valid), 32'd1);
        if (expect_idle && k < NN) chk("R4 early", 32'(out_valid), 32'd0);
      end
      t++;
    end
    in_valid = 1'b0;
  endtask

  task automatic read_tile(logic [15:0] base, logic [7:0] stall);
    int j = 0, t = 0;
    logic [W-1:0] held;
    bit waiting = 0;
    while (j < NN) begin
      @(negedge clk);
      if (waiting) begin
        chk("R5 hold valid", 32'(out_valid), 32'd1);
        chk("R5 hold data", 32'(out_data), 32'(held));
      end
      out_ready = !(stall[t % 8] && lfsr[0]);
      t++;
      if (out_valid) begin
        if (out_ready) begin
          chk("R2 transpose", 32'(out_data), 32'(elem(base, j % N, j / N)));
          j++;
          waiting = 0;
        end else begin
          held = out_data;
          waiting = 1;
        end
      end
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    chk("R1 both_pending", 32'(both_pending), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 32'({out_valid, in_ready, both_pending}), 32'b010);

    for (int i = 0; i < NSC; i++) begin
      fork
        write_tile(SCEN[i].base, SCEN[i].in_gap, 1'b1);
        read_tile(SCEN[i].base, SCEN[i].out_stall);
      join
      @(negedge clk);
      chk("R8 drained", 32'(out_valid), 32'd0);
    end

    // R6/R7: fill both slots with the reader stalled
    out_ready = 1'b0;
    write_tile(16'h4000, 8'h00, 1'b0);
    write_tile(16'h5000, 8'h00, 1'b0);
    @(negedge clk);
    chk("R7 both pending", 32'(both_pending), 32'd1);
    chk("R7 in_ready low", 32'(in_ready), 32'd0);
    // offer a word while blocked; it must wait
    in_valid = 1'b1;
    in_data  = elem(16'h6000, 0, 0);
    repeat (4) @(negedge clk);
    chk("R7 still blocked", 32'(in_ready), 32'd0);
    in_valid = 1'b0;
    chk("R6 older tile first", 32'(out_data), 32'(elem(16'h4000, 0, 0)));
    // drain the older tile, check in_ready returns right after the final read
    for (int j = 0; j < NN; j++) begin
      out_ready = 1'b1;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk("R7 ready after drain", 32'(in_ready), 32'd1);
    chk("R7 pending cleared", 32'(both_pending), 32'd0);
    chk("R6 next tile valid", 32'(out_valid), 32'd1);
    fork
      write_tile(16'h6000, 8'h21, 1'b0);
      read_tile(16'h5000, 8'hFF);
    join
    read_tile(16'h6000, 8'h0F);
    @(negedge clk);
    chk("R8 empty at end", 32'(out_valid), 32'd0);
    summary();
  end
endmodule